// File: doc/BRIEF.md
# Glitch-Free Card Clock Generator

This block derives the clock driven to an SD card from the host system clock. A programmable divider sets the rate. A value of zero passes the system clock through unchanged. Any other value N gives a clock of 2N system cycles with equal high and low times. A software enable gates the output, and a status flag tells software when the divided clock has settled so that it can safely enable it again.

A new divider value or a software reset request must never reach the card as a shortened pulse. Two things guarantee this. First, a new value is adopted only once the output gate has closed, and only at the rising point of the divided clock. Second, the gate opens only while the status flag is set. The gate changes only while the output is low: on the falling source edge in pass-through mode, and at a low point of the divided clock otherwise.

Software may use the safe sequence: disable, change the value or pulse the reset, wait for the flag, then enable. If software changes the value while the clock is enabled, the block still closes the gate by itself until the new rate has settled.

Top module: `sdclk_gen`

## Requirements
- R1: While `rst_n` is low, `card_clk` and `clk_stable` are both low.
- R2: With divider value N from 1 to 2**DIV_W-1 applied and the gate open, every high phase of `card_clk` lasts exactly N system clock periods and every low phase lasts exactly N periods.
- R3: With divider value 0 applied and the gate open, `card_clk` follows `clk`, so each high phase is half a system clock period.
- R4: `clk_stable` reads low in the cycle after `div_val` differs from the applied value. It rises only after STABLE_PERIODS card-clock periods have elapsed since the new value was applied, which is 2N system cycles each (1 cycle for value 0).
- R5: `card_clk` is held low while `clk_en` is low, and also while `clk_stable` is low, even if `clk_en` is high.
- R6: No high phase of `card_clk` is shorter than the nominal high time of the old or the new divider value, and no low phase is shorter than the smaller of the two.
- R7: A divider change made while the clock is enabled is adopted only after the gate has closed. The clock then resumes at the new rate once `clk_stable` is set again.
- R8: While `sw_rst` is high, `card_clk` is held low and `clk_stable` is low. After release, `clk_stable` returns between (STABLE_PERIODS-1) and STABLE_PERIODS card-clock periods later, and the clock then resumes.
- R9: Setting `clk_en` once `clk_stable` is high starts `card_clk` within one card-clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (source) clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| clk_en | input | 1 | Software card-clock enable |
| div_val | input | DIV_W | Divider setting: 0 passes through, N divides by 2N |
| sw_rst | input | 1 | Software reset request, level, active high |
| card_clk | output | 1 | Clock driven to the card |
| clk_stable | output | 1 | High once the divided clock has settled |

## Verification
The bench builds the block with DIV_W=3, STABLE_PERIODS=2 and ZERO_BYPASS=1. At this size every divider value, including pass-through, can be swept. So can changes between neighbouring and distant values in both directions, both with the clock disabled and while it runs. A monitor times every edge of `card_clk` against the nominal phase lengths, which it computes from the old and new values. Settling latency after value changes and reset releases is checked against bounds derived from the card-clock period.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
   typedef enum logic {
      MODE_DIV  = 1'b0,
      MODE_PASS = 1'b1
   } sdclk_mode_e;
endpackage

// File: rtl/sdclk_divider.sv
module sdclk_divider
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W       = 4,
   parameter bit          ZERO_BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_req,
   input  logic             gate_closed,
   output logic [DIV_W-1:0] cur_div,
   output logic [DIV_W-1:0] eff_req,
   output logic             div_q,
   output logic             tick,
   output sdclk_mode_e      mode
);
   logic [DIV_W-1:0] cnt;
   logic             term;
   logic             load;

   generate
      if (ZERO_BYPASS) begin : g_pass
         assign eff_req = div_req;
      end else begin : g_nopass
         assign eff_req = (div_req == '0) ? DIV_W'(1) : div_req;
      end
   endgenerate

   assign term = (cur_div != '0) && (cnt == cur_div - 1'b1);
   // rising point of the divided clock (every source cycle in pass-through)
   assign tick = (cur_div == '0) | (term & ~div_q);
   assign load = tick & gate_closed & (eff_req != cur_div);
   assign mode = (cur_div == '0) ? MODE_PASS : MODE_DIV;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_div <= '0;
         cnt     <= '0;
         div_q   <= 1'b0;
      end else if (load) begin
         cur_div <= eff_req;
         cnt     <= '0;
         div_q   <= (eff_req != '0);
      end else if (term) begin
         cnt     <= '0;
         div_q   <= ~div_q;
      end else if (cur_div != '0) begin
         cnt     <= cnt + 1'b1;
      end
   end

   // R7: the applied value only moves while the gate was closed
   a_r7_load_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_div != $past(cur_div)) |-> $past(gate_closed));
endmodule

// File: rtl/sdclk_stable.sv
module sdclk_stable #(
   parameter int unsigned STABLE_PERIODS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic changed,
   input  logic sw_rst,
   input  logic tick,
   output logic stable
);
   localparam int unsigned SW = $clog2(STABLE_PERIODS + 1);
   localparam logic [SW-1:0] TARGET = SW'(STABLE_PERIODS);

   logic [SW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (changed | sw_rst) begin
         cnt <= '0;
      end else if (tick && (cnt != TARGET)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign stable = (cnt == TARGET);

   // R4: a pending value drops the flag on the next edge
   a_r4_clear_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      changed |=> !stable);
   // R8: a reset request drops the flag on the next edge
   a_r8_clear_on_swrst: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> !stable);
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate
   import sdclk_pkg::*;
#(
   parameter bit ZERO_BYPASS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clk_en,
   input  logic        stable,
   input  logic        sw_rst,
   input  sdclk_mode_e mode,
   input  logic        div_q,
   output logic        gate_closed,
   output logic        card_clk
);
   logic req;
   logic gate_q;
   logic byp_en;

   assign req = clk_en & stable & ~sw_rst;

   // divided path: gate moves only while the divided clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gate_q <= 1'b0;
      else if (!div_q) gate_q <= req;
   end

   // pass-through path: gate moves on the falling source edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) byp_en <= 1'b0;
      else        byp_en <= gate_q;
   end

   assign gate_closed = ~gate_q & ~byp_en;

   generate
      if (ZERO_BYPASS) begin : g_mux
         assign card_clk = (mode == MODE_PASS) ? (clk & byp_en) : (div_q & gate_q);
      end else begin : g_div_only
         assign card_clk = div_q & gate_q;
      end
   endgenerate

   // R5: a closed gate means an idle output
   a_r5_closed_is_low: assert property (@(posedge clk) disable iff (!rst_n)
      gate_closed |-> !card_clk);
   // R5: the gate never opens without the settled flag
   a_r5_open_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q) |-> $past(stable));
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W          = 4,
   parameter int unsigned STABLE_PERIODS = 2,
   parameter bit          ZERO_BYPASS    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic [DIV_W-1:0] div_val,
   input  logic             sw_rst,
   output logic             card_clk,
   output logic             clk_stable
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
         $error("sdclk_gen: DIV_W must be 1..16");
      end
      if (STABLE_PERIODS < 1 || STABLE_PERIODS > 7) begin : g_bad_stable
         $error("sdclk_gen: STABLE_PERIODS must be 1..7");
      end
   endgenerate

   logic [DIV_W-1:0] cur_div;
   logic [DIV_W-1:0] eff_req;
   logic             div_q;
   logic             tick;
   logic             gate_closed;
   sdclk_mode_e      mode;

   sdclk_divider #(.DIV_W(DIV_W), .ZERO_BYPASS(ZERO_BYPASS)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_req    (div_val),
      .gate_closed(gate_closed),
      .cur_div    (cur_div),
      .eff_req    (eff_req),
      .div_q      (div_q),
      .tick       (tick),
      .mode       (mode)
   );

   sdclk_stable #(.STABLE_PERIODS(STABLE_PERIODS)) u_stab (
      .clk    (clk),
      .rst_n  (rst_n),
      .changed(eff_req != cur_div),
      .sw_rst (sw_rst),
      .tick   (tick),
      .stable (clk_stable)
   );

   sdclk_gate #(.ZERO_BYPASS(ZERO_BYPASS)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en     (clk_en),
      .stable     (clk_stable),
      .sw_rst     (sw_rst),
      .mode       (mode),
      .div_q      (div_q),
      .gate_closed(gate_closed),
      .card_clk   (card_clk)
   );
endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int T_NS = 10;
   localparam int DW   = 3;
   localparam int SP   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b0;
   logic          sw_rst = 1'b0;
   logic [DW-1:0] div_val = '0;
   logic          card_clk;
   logic          clk_stable;

   int      n_chk = 0;
   int      n_bad = 0;
   int      rises = 0;
   int      cur_v = 0;
   int      prev_v = 0;
   bit      mon_on = 1'b0;
   realtime t_last = 0.0;

   sdclk_gen #(.DIV_W(DW), .STABLE_PERIODS(SP), .ZERO_BYPASS(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .div_val(div_val),
      .sw_rst(sw_rst), .card_clk(card_clk), .clk_stable(clk_stable)
   );

   always #(T_NS / 2.0) clk = ~clk;

   function automatic real nom(int v);
      return (v == 0) ? T_NS / 2.0 : real'(v * T_NS);
   endfunction

   function automatic int per(int v);
      return (v == 0) ? 1 : 2 * v;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick_n(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   // phase monitor (R2/R3/R6), widths reported in units of 100 ps
   always @(card_clk) begin
      realtime now;
      real     w;
      real     lo_min;
      now = $realtime;
      if (mon_on) begin
         w = now - t_last;
         lo_min = (nom(cur_v) < nom(prev_v)) ? nom(cur_v) : nom(prev_v);
         if (!card_clk) begin
            check((w == nom(cur_v)) || (w == nom(prev_v)), "R2/R3/R6",
                  "high phase", int'(w * 10.0), int'(nom(cur_v) * 10.0));
         end else begin
            rises++;
            check(w >= lo_min, "R2/R6", "low phase", int'(w * 10.0), int'(lo_min * 10.0));
         end
      end
      t_last = now;
   end

   task automatic run_step(int v);
      int p;
      int hi;
      int k;
      int r0;
      p = cur_v;
      clk_en = 1'b0;
      tick_n(per(p) + 3);
      hi = 0;
      repeat (per(p) + 1) begin
         tick_n(1);
         if (card_clk) hi++;
      end
      check(hi == 0, "R5", "highs while disabled", hi, 0);
      prev_v = p;
      cur_v = v;
      div_val = DW'(v);
      k = 0;
      for (int i = 1; i <= 4 * SP * per(v) + 2 * per(p) + 8; i++) begin
         tick_n(1);
         if (i == 1) check(!clk_stable, "R4", "flag after change", int'(clk_stable), 0);
         if (clk_stable) begin
            k = i;
            break;
         end
      end
      check((k >= SP * per(v) + 1) && (k <= SP * per(v) + per(p) + 1), "R4",
            "settle cycles", k, SP * per(v) + 1);
      r0 = rises;
      clk_en = 1'b1;
      tick_n(8 * per(v) + 4);
      check(rises - r0 >= 5, "R9", "rises after enable", rises - r0, 5);
      sw_rst = 1'b1;
      tick_n(per(v) + 2);
      hi = 0;
      repeat (2 * per(v)) begin
         tick_n(1);
         if (card_clk) hi++;
      end
      check(hi == 0, "R8", "highs during reset", hi, 0);
      check(!clk_stable, "R8", "flag during reset", int'(clk_stable), 0);
      sw_rst = 1'b0;
      k = 0;
      for (int i = 1; i <= 4 * SP * per(v) + 8; i++) begin
         tick_n(1);
         if (clk_stable) begin
            k = i;
            break;
         end
      end
      check((k >= (SP - 1) * per(v) + 1) && (k <= SP * per(v)), "R8",
            "resettle cycles", k, SP * per(v));
      r0 = rises;
      tick_n(4 * per(v) + 4);
      check(rises - r0 >= 3, "R8", "rises after release", rises - r0, 3);
   endtask

   task automatic run_live(int w);
      int p;
      int hi;
      int k;
      int r0;
      int lim;
      p = cur_v;
      prev_v = p;
      cur_v = w;
      div_val = DW'(w);
      lim = 2 * SP * per(w) + 3 * per(p) + 10;
      hi = 0;
      k = 0;
      for (int i = 1; i <= lim; i++) begin
         tick_n(1);
         if (clk_stable) begin
            k = i;
            break;
         end
         if ((i > per(p) + 3) && card_clk) hi++;
      end
      check(hi == 0, "R5", "highs while unsettled", hi, 0);
      check((k > 0) && (k >= SP * per(w) + 1), "R7", "live settle cycles", k, SP * per(w) + 1);
      r0 = rises;
      tick_n(6 * per(w) + 4);
      check(rises - r0 >= 4, "R7", "rises at new rate", rises - r0, 4);
   endtask

   initial begin
      #(real'(T_NS) * 150000.0);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int k;
      int seq[10] = '{1, 2, 3, 4, 5, 6, 7, 0, 3, 1};
      int live[4] = '{0, 5, 1, 2};
      repeat (4) @(posedge clk);
      #2;
      check(card_clk == 1'b0, "R1", "card clock in reset", int'(card_clk), 0);
      check(clk_stable == 1'b0, "R1", "flag in reset", int'(clk_stable), 0);
      tick_n(1);
      check(card_clk == 1'b0, "R1", "card clock in reset", int'(card_clk), 0);
      rst_n = 1'b1;
      t_last = $realtime;
      mon_on = 1'b1;
      k = 0;
      for (int i = 1; i <= 10; i++) begin
         tick_n(1);
         if (clk_stable) begin
            k = i;
            break;
         end
      end
      check(k == SP, "R4", "settle after reset", k, SP);
      foreach (seq[i]) run_step(seq[i]);
      foreach (live[i]) run_live(live[i]);
      clk_en = 1'b0;
      tick_n(3 * per(cur_v) + 4);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule